// File: doc/BRIEF.md
# Subblock-Terminated Recursive Systematic Convolutional Encoder

This block is one constituent encoder of a turbo code. It takes a serial stream of information bits, cuts each frame into consecutive subblocks of a programmable length, and encodes every subblock as a separate trellis segment. Each segment starts in the all-zeros state. After its last information bit, three tail steps return the trellis to the all-zeros state. A decoder can therefore process every subblock on its own, with both recursions started from a known state.

Each information bit produces one systematic/parity pair. Each subblock adds three tail pairs. While the tail is being produced, the block holds off input by dropping its ready signal. The subblock length is sampled when the first bit of a frame is accepted. A frame whose length is not a multiple of the subblock length ends in a shorter subblock, which is terminated in the same way.

Top module: `sbt_rsc_encoder`

## Requirements
- R1: On an information step the systematic output equals the accepted bit. The parity is computed with a 3-bit state (s1 newest, s3 oldest):
  - the recursive value is a = u ^ s2 ^ s3, which is feedback polynomial 1 + D^2 + D^3;
  - the parity is a ^ s1 ^ s3, which is feedforward polynomial 1 + D + D^3;
  - the next state is (a, s1, s2).
- R2: Every subblock, including the first one of a frame, is encoded starting from the all-zeros state.
- R3: The last information bit of a subblock is followed by exactly three tail steps. In each tail step the input is s2 ^ s3, so a = 0. That input is emitted as the systematic bit, with parity s1 ^ s3. After the third tail step the state is zero.
- R4: `out_tail` is 1 on the three tail pairs and 0 on information pairs. `out_sub_end` is 1 only on the third tail pair of each subblock.
- R5: `sub_len` is captured when a bit with `in_sof` = 1 is accepted. Changes to it at any other time have no effect on the current frame.
- R6: A bit accepted with `in_eof` = 1 closes its subblock, even if the subblock is shorter than `sub_len`. That subblock is terminated as in R3.
- R7: `in_ready` is 0 for exactly the three cycles in which tail pairs are computed, and 1 otherwise.
- R8: Every accepted bit produces its output pair on the next cycle. When input is valid on every ready cycle, `out_valid` stays high with no gap from the first pair of a frame to its last tail pair.
- R9: After reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input bit is valid |
| in_bit | input | 1 | Information bit |
| in_sof | input | 1 | Bit is the first of a frame |
| in_eof | input | 1 | Bit is the last of a frame |
| sub_len | input | LEN_W | Subblock length in bits, 1 or more, sampled at frame start |
| in_ready | output | 1 | Block accepts a bit this cycle |
| out_valid | output | 1 | Output pair is valid |
| out_sys | output | 1 | Systematic bit (tail input on tail steps) |
| out_par | output | 1 | Parity bit |
| out_tail | output | 1 | Pair belongs to a termination tail |
| out_sub_end | output | 1 | Last tail pair of a subblock |

## Verification
The assertions assume the following about the inputs:
- a frame opens with `in_sof` and closes with `in_eof`;
- no new `in_sof` arrives before the previous frame's last tail;
- the latched `sub_len` is never zero.

The stimulus follows these rules. It sends whole frames, each with one start bit and one end bit, and always draws the subblock length from a nonzero set. It changes `sub_len` only in one deliberate mid-frame case. It offers a bit only after observing `in_ready`, and holds that bit steady during stalls.

// File: rtl/sbt_rsc_pkg.sv
package sbt_rsc_pkg;
    localparam int MEM_LEN = 3;
    localparam int TCNT_W  = 2;

    typedef enum logic {
        PH_INFO = 1'b0,
        PH_TAIL = 1'b1
    } phase_e;
endpackage

// File: rtl/rsc_step.sv
module rsc_step
    import sbt_rsc_pkg::*;
(
    input  logic [MEM_LEN-1:0] st_in,
    input  logic               bit_in,
    input  logic               tail_mode,
    output logic               sys_out,
    output logic               par_out,
    output logic [MEM_LEN-1:0] st_out
);
    logic fb;
    logic u;
    logic a;

    always_comb begin
        fb      = st_in[1] ^ st_in[2];
        u       = tail_mode ? fb : bit_in;
        a       = u ^ fb;
        sys_out = u;
        par_out = a ^ st_in[0] ^ st_in[2];
        st_out  = {st_in[1], st_in[0], a};
    end
endmodule

// File: rtl/seg_track.sv
module seg_track #(
    parameter int LEN_W = 8
) (
    input  logic [LEN_W-1:0] cnt_q,
    input  logic [LEN_W-1:0] len_q,
    input  logic [LEN_W-1:0] len_new,
    input  logic             sof,
    input  logic             eof,
    output logic [LEN_W-1:0] len_eff,
    output logic [LEN_W-1:0] cnt_eff,
    output logic             last_bit
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    always_comb begin
        len_eff  = sof ? len_new : len_q;
        cnt_eff  = sof ? '0 : cnt_q;
        last_bit = eof || (cnt_eff == (len_eff - ONE));
    end
endmodule

// File: rtl/sbt_rsc_encoder.sv
module sbt_rsc_encoder
    import sbt_rsc_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_bit,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic [LEN_W-1:0] sub_len,
    output logic             in_ready,
    output logic             out_valid,
    output logic             out_sys,
    output logic             out_par,
    output logic             out_tail,
    output logic             out_sub_end
);
    localparam logic [TCNT_W-1:0] TAIL_LAST = TCNT_W'(MEM_LEN - 1);

    typedef struct packed {
        phase_e             ph;
        logic [LEN_W-1:0]   cnt;
        logic [LEN_W-1:0]   len;
        logic [TCNT_W-1:0]  tcnt;
        logic [MEM_LEN-1:0] st;
        logic               o_valid;
        logic               o_sys;
        logic               o_par;
        logic               o_tail;
        logic               o_end;
    } regs_t;

    regs_t r_q;
    regs_t r_d;

    logic               step_sys;
    logic               step_par;
    logic [MEM_LEN-1:0] step_st;
    logic [LEN_W-1:0]   len_eff;
    logic [LEN_W-1:0]   cnt_eff;
    logic               last_bit;
    logic [MEM_LEN-1:0] trellis_st;

    rsc_step u_step (
        .st_in     (r_q.st),
        .bit_in    (in_bit),
        .tail_mode (r_q.ph == PH_TAIL),
        .sys_out   (step_sys),
        .par_out   (step_par),
        .st_out    (step_st)
    );

    seg_track #(.LEN_W(LEN_W)) u_seg (
        .cnt_q    (r_q.cnt),
        .len_q    (r_q.len),
        .len_new  (sub_len),
        .sof      (in_sof),
        .eof      (in_eof),
        .len_eff  (len_eff),
        .cnt_eff  (cnt_eff),
        .last_bit (last_bit)
    );

    always_comb begin
        r_d         = r_q;
        r_d.o_valid = 1'b0;
        r_d.o_tail  = 1'b0;
        r_d.o_end   = 1'b0;
        if (r_q.ph == PH_INFO) begin
            if (in_valid) begin
                r_d.o_valid = 1'b1;
                r_d.o_sys   = step_sys;
                r_d.o_par   = step_par;
                r_d.st      = step_st;
                r_d.len     = len_eff;
                if (last_bit) begin
                    r_d.ph   = PH_TAIL;
                    r_d.tcnt = '0;
                    r_d.cnt  = '0;
                end else begin
                    r_d.cnt  = cnt_eff + LEN_W'(1);
                end
            end
        end else begin
            r_d.o_valid = 1'b1;
            r_d.o_tail  = 1'b1;
            r_d.o_sys   = step_sys;
            r_d.o_par   = step_par;
            r_d.st      = step_st;
            if (r_q.tcnt == TAIL_LAST) begin
                r_d.o_end = 1'b1;
                r_d.ph    = PH_INFO;
                r_d.tcnt  = '0;
            end else begin
                r_d.tcnt  = r_q.tcnt + TCNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q         <= '0;
            r_q.ph      <= PH_INFO;
            r_q.len     <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign in_ready    = (r_q.ph == PH_INFO);
    assign out_valid   = r_q.o_valid;
    assign out_sys     = r_q.o_sys;
    assign out_par     = r_q.o_par;
    assign out_tail    = r_q.o_tail;
    assign out_sub_end = r_q.o_end;
    assign trellis_st  = r_q.st;
endmodule

// File: rtl/sbt_rsc_checks.sv
module sbt_rsc_checks (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_ready,
    input logic       out_valid,
    input logic       out_tail,
    input logic       out_sub_end,
    input logic [2:0] trellis_st
);
    AST_END_IS_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        out_sub_end |-> (out_valid && out_tail)); // R4

    AST_ZERO_AFTER_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        out_sub_end |-> (trellis_st == 3'b000)); // R3

    AST_TAIL_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_tail && !out_sub_end) |=> (out_valid && out_tail)); // R3

    AST_THREE_TAILS: assert property (@(posedge clk) disable iff (!rst_n)
        out_sub_end |-> ($past(out_tail) && $past(out_tail, 2))); // R3

    AST_STALL_IN_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> (out_valid && out_tail)); // R7

    AST_READY_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        out_sub_end |-> in_ready); // R7

    AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_valid && !out_tail)); // R8
endmodule

bind sbt_rsc_encoder sbt_rsc_checks chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_tail    (out_tail),
    .out_sub_end (out_sub_end),
    .trellis_st  (trellis_st)
);

// File: tb/sbt_rsc_encoder_tb_top.sv
module sbt_rsc_encoder_tb_top;
    localparam int LEN_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_bit = 1'b0;
    logic             in_sof = 1'b0;
    logic             in_eof = 1'b0;
    logic [LEN_W-1:0] sub_len = 8'd1;
    logic             in_ready;
    logic             out_valid;
    logic             out_sys;
    logic             out_par;
    logic             out_tail;
    logic             out_sub_end;

    always #4 clk = ~clk;

    sbt_rsc_encoder #(.LEN_W(LEN_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
        .in_sof(in_sof), .in_eof(in_eof), .sub_len(sub_len),
        .in_ready(in_ready), .out_valid(out_valid), .out_sys(out_sys),
        .out_par(out_par), .out_tail(out_tail), .out_sub_end(out_sub_end)
    );

    int checks = 0;
    int fails = 0;
    logic [4:0] exp_q[$];
    logic       frame_bits[0:63];
    int         exp_total;
    int         exp_subs;
    int         cyc = 0;
    int         first_cyc, last_cyc, n_out, n_stall;
    bit         seen_first;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Bit-level reference: entry = {first_of_sub, sys, par, tail, end}
    task automatic build_frame(input int n, input int sl);
        logic [2:0] st = 3'b000;
        int cnt = 0;
        exp_total = 0;
        exp_subs = 0;
        for (int i = 0; i < n; i++) begin
            logic u, fb, a, p;
            u  = frame_bits[i];
            fb = st[1] ^ st[2];
            a  = u ^ fb;
            p  = a ^ st[0] ^ st[2];
            exp_q.push_back({(cnt == 0), u, p, 1'b0, 1'b0});
            exp_total++;
            st = {st[1], st[0], a};
            cnt++;
            if (cnt == sl || i == n - 1) begin
                for (int t = 0; t < 3; t++) begin
                    fb = st[1] ^ st[2];
                    p  = st[0] ^ st[2];
                    exp_q.push_back({1'b0, fb, p, 1'b1, (t == 2)});
                    exp_total++;
                    st = {st[1], st[0], 1'b0};
                end
                exp_subs++;
                cnt = 0;
            end
        end
    endtask

    task automatic send_frame(input int n, input int sl, input bit gaps,
                              input bit len_change);
        for (int i = 0; i < n; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            frame_bits[i] = lfsr[0];
        end
        build_frame(n, sl);
        seen_first = 1'b0;
        n_out = 0;
        n_stall = 0;
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            if (gaps && (i % 3 == 1)) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_bit   = frame_bits[i];
            in_sof   = (i == 0);
            in_eof   = (i == n - 1);
            sub_len  = (i == 0 || !len_change) ? LEN_W'(sl) : LEN_W'(sl + 3);
            while (!in_ready) @(negedge clk);
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_sof   = 1'b0;
        in_eof   = 1'b0;
        for (int k = 0; k < 8; k++) @(negedge clk);
        chk(n_out == exp_total, (len_change ? "R5" : "R6"), "output pair count",
            n_out, exp_total);
        chk(n_stall == 3 * exp_subs, "R7", "stall cycles", n_stall, 3 * exp_subs);
        if (!gaps)
            chk((last_cyc - first_cyc + 1) == n_out, "R8", "gapless output span",
                last_cyc - first_cyc + 1, n_out);
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (!in_ready) n_stall++;
            if (out_valid) begin
                logic [4:0] e;
                if (!seen_first) begin
                    first_cyc  = cyc;
                    seen_first = 1'b1;
                end
                last_cyc = cyc;
                n_out++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8", "unexpected output", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    if (e[1])
                        chk({out_sys, out_par} == e[3:2], "R3", "tail sys/par",
                            {out_sys, out_par}, e[3:2]);
                    else if (e[4])
                        chk({out_sys, out_par} == e[3:2], "R2", "first pair of subblock",
                            {out_sys, out_par}, e[3:2]);
                    else
                        chk({out_sys, out_par} == e[3:2], "R1", "info sys/par",
                            {out_sys, out_par}, e[3:2]);
                    chk({out_tail, out_sub_end} == e[1:0], "R4", "tail/end flags",
                        {out_tail, out_sub_end}, e[1:0]);
                end
            end
        end
    end

    initial begin
        for (int k = 0; k < 200000; k++) @(posedge clk);
        chk(1'b0, "R8", "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int sls[5] = '{1, 2, 3, 5, 8};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R9", "out_valid after reset", out_valid, 0);
        chk(in_ready == 1'b1, "R9", "in_ready after reset", in_ready, 1);
        foreach (sls[s])
            for (int n = 1; n <= 12; n++)
                send_frame(n, sls[s], 1'b0, 1'b0);
        send_frame(11, 4, 1'b1, 1'b0);
        send_frame(10, 3, 1'b0, 1'b1);
        send_frame(40, 16, 1'b0, 1'b0);
        chk(exp_q.size() == 0, "R8", "leftover expected pairs", exp_q.size(), 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule